// File: doc/BRIEF.md
# Debug Command Acknowledge Pulse Generator

This block sits on the target side of a single-wire, open-drain debug link. When the serial receiver reports that a debug command has finished, the block waits a minimum settling time and then pulls the line low for a short or a long interval. It then drives the line high for one serial-clock cycle to speed up the rising edge, and finally releases the line to its pull-up. A long pulse tells the host that something went wrong. That happens when the command raised an error, when a memory access request was never granted, or when the part entered a stop or wait low-power mode since the last acknowledge.

Pulse timing is counted in serial-interface cycles, marked by a one-cycle `si_tick` enable in the core clock domain. The access timeout is counted in core clock cycles. The host can cancel a pending or running acknowledge with an abort strobe, which the serial receiver raises after it detects a long low sync request. The no-response error is sticky and is cleared by a separate strobe.

Top module: `dbg_ack_gen`

## Requirements
- R1: A normal acknowledge pulls the line low for 16 serial cycles, then drives it high for exactly 1 serial cycle, then releases it (both enables 0).
- R2: The low pulse never starts before 32 serial cycles have passed since the accepted command-end strobe. With `si_tick` held at 1 and no access pending, `line_pull_low` is first high 33 core cycles after the clock edge that sampled `cmd_done`.
- R3: If `cmd_err` is 1 at the command-end strobe, the acknowledge is long: 64 serial cycles low, followed by the 1-cycle speedup pulse.
- R4: A command flagged `cmd_with_status` = 1 produces no pulse, even when `ack_en` = 1.
- R5: With `ack_en` = 0 at the command-end strobe, no pulse is produced.
- R6: If `acc_req` is 1 at the strobe, the acknowledge waits for `acc_grant`. With the minimum delay already met, the low pulse starts one cycle after the edge that sampled the grant, and it is a normal pulse.
- R7: If the grant does not come within 512 core cycles of the strobe edge, the request is dropped. `noresp_flag` rises 512 cycles after that edge, and a long acknowledge starts one cycle later.
- R8: `noresp_flag` stays 1 until `noresp_clr` is pulsed, after which it reads 0.
- R9: A `lp_entry` pulse while `dbg_en` = 1 makes the next acknowledge long, and it does so once only. A `lp_entry` pulse while `dbg_en` = 0 has no effect.
- R10: `abort` returns the block to idle. A pending acknowledge is never driven, and a running low pulse ends at once with no speedup pulse. A later command is acknowledged normally.
- R11: A `cmd_done` strobe that arrives while an acknowledge is pending or running is ignored and does not move the pulse start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| si_tick | input | 1 | One-cycle enable marking a serial-interface clock cycle |
| cmd_done | input | 1 | Command-end strobe (16th serial cycle of the last bit) |
| cmd_with_status | input | 1 | Command is of the with-status type |
| ack_en | input | 1 | Acknowledge pulses enabled |
| cmd_err | input | 1 | The finished command raised an error |
| acc_req | input | 1 | The command started a memory access request |
| acc_grant | input | 1 | The memory access request was granted |
| lp_entry | input | 1 | Strobe: stop or wait mode entered |
| dbg_en | input | 1 | Debug logic enabled |
| abort | input | 1 | Cancel any pending or running acknowledge |
| noresp_clr | input | 1 | Clear the no-response flag |
| line_pull_low | output | 1 | Enable for the open-drain pull-down |
| line_drive_high | output | 1 | Enable for the speedup high drive |
| noresp_flag | output | 1 | Sticky access-timeout error |

## Verification
Each result has a fixed arrival cycle, counted from the edge that samples the command-end strobe. The low pulse appears 33 cycles after it, the speedup pulse 16 or 64 cycles after the low pulse starts, a grant-released pulse one cycle after the grant edge, and the timeout flag 512 cycles after it with the long pulse one cycle later. The bench samples every output on the falling edge after each rising edge and records the first cycle index at which each output rises and how many cycles it stays high. It compares those indices and lengths against the values above. Grant, abort and extra strobes are driven at the falling edge just before the rising edge named in the test.

// File: rtl/dbg_ack_pkg.sv
package dbg_ack_pkg;

   typedef enum logic [1:0] {
      ACK_IDLE = 2'd0,
      ACK_WAIT = 2'd1,
      ACK_LOW  = 2'd2,
      ACK_SPD  = 2'd3
   } ack_state_e;

endpackage

// File: rtl/dbg_ack_delay.sv
module dbg_ack_delay #(
   parameter int unsigned DLY = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   output logic done
);

   localparam int unsigned W = $clog2(DLY + 1);
   localparam logic [W-1:0] LIMIT = W'(DLY);

   generate
      if (DLY < 1) begin : g_bad_dly
         $error("dbg_ack_delay: DLY must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= LIMIT;
      end else if (start) begin
         cnt <= '0;
      end else if (tick && (cnt != LIMIT)) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign done = (cnt == LIMIT);

   AST_DLY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !done) else $error("delay not restarted"); // R2

endmodule

// File: rtl/dbg_ack_acc_watch.sv
module dbg_ack_acc_watch #(
   parameter int unsigned TMO = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic grant,
   input  logic cancel,
   output logic pend,
   output logic expire
);

   localparam int unsigned W = $clog2(TMO);
   localparam logic [W-1:0] LAST = W'(TMO - 1);

   generate
      if (TMO < 2) begin : g_bad_tmo
         $error("dbg_ack_acc_watch: TMO must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt;

   assign expire = pend && !grant && !cancel && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         cnt  <= '0;
      end else if (arm) begin
         pend <= 1'b1;
         cnt  <= '0;
      end else if (pend) begin
         if (cancel || grant || expire) begin
            pend <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   AST_EXPIRE_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !pend) else $error("request not dropped on timeout"); // R7

   AST_GRANT_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && grant && !arm) |=> !pend) else $error("grant ignored"); // R6

endmodule

// File: rtl/dbg_ack_gen.sv
module dbg_ack_gen #(
   parameter int unsigned MIN_DLY  = 32,
   parameter int unsigned LEN_NORM = 16,
   parameter int unsigned LEN_LONG = 64,
   parameter int unsigned ACC_TMO  = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic si_tick,
   input  logic cmd_done,
   input  logic cmd_with_status,
   input  logic ack_en,
   input  logic cmd_err,
   input  logic acc_req,
   input  logic acc_grant,
   input  logic lp_entry,
   input  logic dbg_en,
   input  logic abort,
   input  logic noresp_clr,
   output logic line_pull_low,
   output logic line_drive_high,
   output logic noresp_flag
);

   import dbg_ack_pkg::*;

   localparam int unsigned PW = $clog2(LEN_LONG);
   localparam logic [PW-1:0] NORM_LAST = PW'(LEN_NORM - 1);
   localparam logic [PW-1:0] LONG_LAST = PW'(LEN_LONG - 1);

   generate
      if (LEN_NORM < 1 || LEN_LONG <= LEN_NORM) begin : g_bad_len
         $error("dbg_ack_gen: need 1 <= LEN_NORM < LEN_LONG");
      end
   endgenerate

   ack_state_e state;
   logic [PW-1:0] pcnt;
   logic ack_q, err_q, long_q, lp_pend;
   logic accept, dly_done, acc_pend, acc_expire, go, start_pulse;
   logic [PW-1:0] len_last;

   assign accept      = (state == ACK_IDLE) && cmd_done && !abort;
   assign go          = (state == ACK_WAIT) && dly_done && !acc_pend && !abort;
   assign start_pulse = go && ack_q;
   assign len_last    = long_q ? LONG_LAST : NORM_LAST;

   dbg_ack_delay #(.DLY(MIN_DLY)) i_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .tick  (si_tick),
      .done  (dly_done)
   );

   dbg_ack_acc_watch #(.TMO(ACC_TMO)) i_watch (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (accept && acc_req),
      .grant  (acc_grant),
      .cancel (abort),
      .pend   (acc_pend),
      .expire (acc_expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ACK_IDLE;
         pcnt   <= '0;
         ack_q  <= 1'b0;
         err_q  <= 1'b0;
         long_q <= 1'b0;
      end else if (abort) begin
         state <= ACK_IDLE;
      end else begin
         unique case (state)
            ACK_IDLE: begin
               if (cmd_done) begin
                  state <= ACK_WAIT;
                  ack_q <= ack_en && !cmd_with_status;
                  err_q <= cmd_err;
               end
            end
            ACK_WAIT: begin
               if (acc_expire) begin
                  err_q <= 1'b1;
               end
               if (go) begin
                  if (ack_q) begin
                     state  <= ACK_LOW;
                     long_q <= err_q || lp_pend;
                     pcnt   <= '0;
                  end else begin
                     state <= ACK_IDLE;
                  end
               end
            end
            ACK_LOW: begin
               if (si_tick) begin
                  if (pcnt == len_last) begin
                     state <= ACK_SPD;
                  end else begin
                     pcnt <= pcnt + 1'b1;
                  end
               end
            end
            ACK_SPD: begin
               if (si_tick) begin
                  state <= ACK_IDLE;
               end
            end
            default: state <= ACK_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lp_pend <= 1'b0;
      end else if (lp_entry && dbg_en) begin
         lp_pend <= 1'b1;
      end else if (start_pulse) begin
         lp_pend <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         noresp_flag <= 1'b0;
      end else if (acc_expire) begin
         noresp_flag <= 1'b1;
      end else if (noresp_clr) begin
         noresp_flag <= 1'b0;
      end
   end

   assign line_pull_low   = (state == ACK_LOW);
   assign line_drive_high = (state == ACK_SPD);

   AST_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_pull_low) |-> dly_done) else $error("ack too early"); // R2

   AST_NOT_WHILE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_pull_low) |-> !acc_pend) else $error("ack before grant"); // R6

   AST_SPEEDUP_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (line_drive_high && si_tick && !abort) |=> !line_drive_high && !line_pull_low) else $error("speedup too long"); // R1

   AST_NORESP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (noresp_flag && !noresp_clr) |=> noresp_flag) else $error("noresp lost"); // R8

   AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !line_pull_low && !line_drive_high) else $error("abort ignored"); // R10

endmodule

// File: tb/test_dbg_ack_gen.sv
`timescale 1ns/1ps
module test_dbg_ack_gen;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic si_tick = 1'b1;
   logic cmd_done = 1'b0, cmd_with_status = 1'b0, ack_en = 1'b1, cmd_err = 1'b0;
   logic acc_req = 1'b0, acc_grant = 1'b0, lp_entry = 1'b0, dbg_en = 1'b1;
   logic abort = 1'b0, noresp_clr = 1'b0;
   logic line_pull_low, line_drive_high, noresp_flag;

   int vectors = 0;
   int miscompares = 0;

   always #10 clk = ~clk;

   dbg_ack_gen i_dbg_ack_gen (
      .clk(clk), .rst_n(rst_n), .si_tick(si_tick), .cmd_done(cmd_done),
      .cmd_with_status(cmd_with_status), .ack_en(ack_en), .cmd_err(cmd_err),
      .acc_req(acc_req), .acc_grant(acc_grant), .lp_entry(lp_entry),
      .dbg_en(dbg_en), .abort(abort), .noresp_clr(noresp_clr),
      .line_pull_low(line_pull_low), .line_drive_high(line_drive_high),
      .noresp_flag(noresp_flag)
   );

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // index i = sample on the falling edge after rising edge Ei; E0 samples cmd_done
   task automatic capture(input int max_i, input int grant_edge, input int abort_edge,
                          input int cmd2_edge, output int f_low, output int n_low,
                          output int f_spd, output int n_spd, output int f_nr);
      f_low = -1; n_low = 0; f_spd = -1; n_spd = 0; f_nr = -1;
      @(negedge clk);
      cmd_done = 1'b1;
      for (int i = 0; i <= max_i; i++) begin
         @(negedge clk);
         if (line_pull_low) begin
            if (f_low < 0) f_low = i;
            n_low++;
         end
         if (line_drive_high) begin
            if (f_spd < 0) f_spd = i;
            n_spd++;
         end
         if (noresp_flag && f_nr < 0) f_nr = i;
         cmd_done  = (i + 1 == cmd2_edge);
         acc_grant = (i + 1 == grant_edge);
         abort     = (i + 1 == abort_edge);
         acc_req   = 1'b0;
         cmd_err   = 1'b0;
      end
      cmd_done = 1'b0; acc_grant = 1'b0; abort = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 reset low", int'(line_pull_low), 0);
      chk("R1 reset high", int'(line_drive_high), 0);
      chk("R8 reset noresp", int'(noresp_flag), 0);
   endtask

   task automatic t_normal();
      int fl, nl, fs, ns, fn;
      capture(80, -1, -1, -1, fl, nl, fs, ns, fn);
      chk("R2 normal start", fl, 33);
      chk("R1 normal low len", nl, 16);
      chk("R1 speedup index", fs, 49);
      chk("R1 speedup len", ns, 1);
   endtask

   task automatic t_error();
      int fl, nl, fs, ns, fn;
      cmd_err = 1'b1;
      capture(120, -1, -1, -1, fl, nl, fs, ns, fn);
      chk("R3 long start", fl, 33);
      chk("R3 long low len", nl, 64);
      chk("R3 speedup index", fs, 97);
      chk("R3 speedup len", ns, 1);
   endtask

   task automatic t_with_status();
      int fl, nl, fs, ns, fn;
      cmd_with_status = 1'b1;
      capture(80, -1, -1, -1, fl, nl, fs, ns, fn);
      cmd_with_status = 1'b0;
      chk("R4 with-status low", nl, 0);
      chk("R4 with-status high", ns, 0);
   endtask

   task automatic t_ack_off();
      int fl, nl, fs, ns, fn;
      ack_en = 1'b0;
      capture(80, -1, -1, -1, fl, nl, fs, ns, fn);
      ack_en = 1'b1;
      chk("R5 ack off low", nl, 0);
      chk("R5 ack off high", ns, 0);
   endtask

   task automatic t_grant();
      int fl, nl, fs, ns, fn;
      acc_req = 1'b1;
      capture(150, 100, -1, -1, fl, nl, fs, ns, fn);
      chk("R6 grant start", fl, 101);
      chk("R6 grant low len", nl, 16);
      chk("R6 no noresp", fn, -1);
   endtask

   task automatic t_timeout();
      int fl, nl, fs, ns, fn;
      acc_req = 1'b1;
      capture(600, -1, -1, -1, fl, nl, fs, ns, fn);
      chk("R7 noresp index", fn, 512);
      chk("R7 long start", fl, 513);
      chk("R7 long len", nl, 64);
      chk("R7 speedup index", fs, 577);
      repeat (20) @(negedge clk);
      chk("R8 noresp held", int'(noresp_flag), 1);
      noresp_clr = 1'b1;
      @(negedge clk);
      noresp_clr = 1'b0;
      chk("R8 noresp cleared", int'(noresp_flag), 0);
   endtask

   task automatic t_low_power();
      int fl, nl, fs, ns, fn;
      dbg_en = 1'b0;
      lp_entry = 1'b1;
      @(negedge clk);
      lp_entry = 1'b0;
      capture(80, -1, -1, -1, fl, nl, fs, ns, fn);
      chk("R9 no effect without debug", nl, 16);
      dbg_en = 1'b1;
      lp_entry = 1'b1;
      @(negedge clk);
      lp_entry = 1'b0;
      capture(120, -1, -1, -1, fl, nl, fs, ns, fn);
      chk("R9 first after entry long", nl, 64);
      capture(80, -1, -1, -1, fl, nl, fs, ns, fn);
      chk("R9 used once", nl, 16);
   endtask

   task automatic t_abort();
      int fl, nl, fs, ns, fn;
      capture(80, -1, 21, -1, fl, nl, fs, ns, fn);
      chk("R10 pending abort low", nl, 0);
      chk("R10 pending abort high", ns, 0);
      capture(80, -1, 40, -1, fl, nl, fs, ns, fn);
      chk("R10 running abort low len", nl, 7);
      chk("R10 running abort high", ns, 0);
      capture(80, -1, -1, -1, fl, nl, fs, ns, fn);
      chk("R10 recovery start", fl, 33);
      chk("R10 recovery len", nl, 16);
   endtask

   task automatic t_nested();
      int fl, nl, fs, ns, fn;
      capture(80, -1, -1, 10, fl, nl, fs, ns, fn);
      chk("R11 busy strobe start", fl, 33);
      chk("R11 busy strobe pulses", nl, 16);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_normal();
      t_error();
      t_with_status();
      t_ack_off();
      t_grant();
      t_timeout();
      t_low_power();
      t_abort();
      t_nested();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule